// File: doc/BRIEF.md
# UDP/IP Header Generator with Live Field Insertion

This block puts a complete Ethernet, IPv4 and UDP header in front of every outgoing payload. Software fills a 32-entry template register file in which each entry holds one 16-bit header word and four control bits. When a packet starts, the block emits the template words in entry order, starting at entry 2, as a 16-bit valid/ready stream. It then hands the output over to the payload stream, which passes through unchanged until its last word.

Three control bits mark entries whose stored data is replaced at emission time: the IP total length, the UDP length, or the IP header checksum. Both lengths are derived from a payload byte count. The block samples that count once, when a packet begins. The checksum is the ones-complement sum of a fixed set of IP header entries, with any length substitution applied, and then inverted. A fourth control bit marks the final header word.

Top module: `udp_hdr_gen`

## Requirements
- R1: After reset and between packets, `out_valid` and `in_ready` are both low.
- R2: A packet starts when `in_valid` is high while the block is idle. The header is then emitted beginning at entry 2, one entry per accepted output word, in ascending order. Entries 0 and 1 are never emitted. While `out_ready` is low, the offered header word is held.
- R3: An entry with none of bits 18, 17 or 16 set is emitted as its stored bits [15:0].
- R4: An entry with bit 17 set is emitted as (byte count + 28) modulo 65536, and its stored data is ignored.
- R5: An entry with bit 16 set is emitted as (byte count + 8) modulo 65536, and its stored data is ignored.
- R6: An entry with bit 18 set is emitted as the bitwise inverse of the end-around-carry ones-complement sum of the values of entries 9 to 13 and 15 to 18. In that sum, an entry carrying bit 17 or bit 16 contributes its inserted length. Bit 18 takes priority over bit 17, and bit 17 takes priority over bit 16.
- R7: After the last header word, each payload word passes to the output with its data and last flag unchanged. `in_ready` follows `out_ready`. `in_ready` is low during the header, and `out_last` is never set on a header word.
- R8: `pkt_bytes` is sampled when the packet starts. Later changes to it do not affect the lengths or the checksum of that packet.
- R9: The handshake of the payload word carrying `in_last` ends the packet. A following packet again starts its header at entry 2.
- R10: If no entry from 2 upward carries bit 19, the header ends with entry 31.
- R11: An entry carrying bit 19 together with an insert bit emits the inserted value and is the last header word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Template entry write strobe |
| cfg_addr | input | 5 | Template entry index |
| cfg_wdata | input | 20 | Entry value: control in [19:16], data in [15:0] |
| pkt_bytes | input | 16 | Payload byte count, sampled at packet start |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Payload word accepted |
| in_data | input | 16 | Payload word |
| in_last | input | 1 | Final payload word of the packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 16 | Header or payload word |
| out_last | output | 1 | Final word of the packet |

## Verification
The bench checks the checksum against a hand-worked IPv4 header. In that header the length entry holds junk data, so a design that summed the stored word, or forgot the end-around carry, produces a wrong checksum. It also changes the byte count in the middle of a packet, which catches a design that reads `pkt_bytes` live instead of latching it. A byte count near 65535 shows whether the lengths wrap or saturate. Header templates that end early on an entry that also carries an insert bit, or that have no end marker at all, expose a sequencer that stops one word late, stops one word early, or runs off the end of the table.

// File: rtl/udp_hdr_gen.sv
module udp_hdr_gen #(
  parameter int DEPTH   = 32,
  parameter int FIRST   = 2,
  parameter int CK_LO   = 9,
  parameter int CK_HI   = 18,
  parameter int CK_SKIP = 14,
  parameter int IP_ADD  = 28,
  parameter int UDP_ADD = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [4:0]  cfg_addr,
  input  logic [19:0] cfg_wdata,
  input  logic [15:0] pkt_bytes,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data,
  output logic        out_last
);
  localparam int AW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY} state_t;

  state_t          state;
  logic [AW-1:0]   idx;
  logic [15:0]     bytes_q;
  logic [19:0]     tmpl [DEPTH];
  logic            in_idle, in_hdr, in_pay, hdr_end;
  logic [15:0]     ip_len, udp_len, cksum, hdr_word;
  logic [23:0]     acc;
  logic [16:0]     fold1;
  logic [15:0]     fold2;
  logic [19:0]     cur;

  function automatic logic [15:0] subst(input logic [19:0] e, input logic [15:0] il,
                                        input logic [15:0] ul);
    if (e[17])      return il;
    else if (e[16]) return ul;
    else            return e[15:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tmpl[i] <= '0;
    end else if (cfg_we) begin
      tmpl[cfg_addr[AW-1:0]] <= cfg_wdata;
    end
  end

  assign in_idle = (state == S_IDLE);
  assign in_hdr  = (state == S_HDR);
  assign in_pay  = (state == S_PAY);

  assign ip_len  = bytes_q + 16'(IP_ADD);
  assign udp_len = bytes_q + 16'(UDP_ADD);

  always_comb begin
    acc = '0;
    for (int i = CK_LO; i <= CK_HI; i++)
      if (i != CK_SKIP) acc = acc + 24'(subst(tmpl[i], ip_len, udp_len));
  end

  assign fold1 = {1'b0, acc[15:0]} + 17'(acc[23:16]);
  assign fold2 = fold1[15:0] + 16'(fold1[16]);
  assign cksum = ~fold2;

  assign cur      = tmpl[idx];
  assign hdr_word = cur[18] ? cksum : subst(cur, ip_len, udp_len);
  assign hdr_end  = cur[19] || (idx == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx     <= '0;
      bytes_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          bytes_q <= pkt_bytes;
          idx     <= AW'(FIRST);
          state   <= S_HDR;
        end
        S_HDR: if (out_ready) begin
          if (hdr_end) state <= S_PAY;
          else         idx   <= idx + 1'b1;
        end
        S_PAY: if (in_valid && out_ready && in_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign out_valid = in_hdr || (in_pay && in_valid);
  assign in_ready  = in_pay && out_ready;
  assign out_data  = in_hdr ? hdr_word : in_data;
  assign out_last  = in_pay && in_last;
endmodule

// File: rtl/udp_hdr_gen_chk.sv
module udp_hdr_gen_chk #(
  parameter int AW    = 5,
  parameter int FIRST = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [15:0]   in_data,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [15:0]   out_data,
  input logic          out_last,
  input logic          in_idle,
  input logic          in_hdr,
  input logic [AW-1:0] idx,
  input logic [15:0]   bytes_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !out_valid && !in_ready); // R1

  AST_HDR_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_hdr) |-> idx == AW'(FIRST)); // R2

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_hdr && !out_ready |=> in_hdr && out_valid && $stable(out_data)); // R2

  AST_HDR_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    in_hdr |-> out_valid && !in_ready && !out_last); // R7

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid |-> out_valid && out_data == in_data && out_last == in_last); // R7

  AST_READY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_ready); // R7

  AST_BYTES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idle && !$past(in_idle) |-> $stable(bytes_q)); // R8
endmodule

bind udp_hdr_gen udp_hdr_gen_chk #(.AW(AW), .FIRST(FIRST)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .in_idle(in_idle), .in_hdr(in_hdr), .idx(idx), .bytes_q(bytes_q)
);

// File: tb/udp_hdr_gen_tb.sv
module udp_hdr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic [15:0] pkt_bytes = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [19:0] tmpl_m [32];
  logic [15:0] got [256];
  logic        gl [256];
  int          ngot;

  always #(CLK_PERIOD/2) clk = ~clk;

  udp_hdr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pkt_bytes(pkt_bytes), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [19:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    tmpl_m[a] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] m_sub(input int i, input logic [15:0] b);
    logic [19:0] e = tmpl_m[i];
    if (e[17]) return b + 16'd28;
    if (e[16]) return b + 16'd8;
    return e[15:0];
  endfunction

  function automatic logic [15:0] m_ck(input logic [15:0] b);
    int s = 0;
    for (int i = 9; i <= 18; i++) if (i != 14) s += int'(m_sub(i, b));
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  function automatic logic [15:0] m_word(input int i, input logic [15:0] b);
    if (tmpl_m[i][18]) return m_ck(b);
    return m_sub(i, b);
  endfunction

  function automatic int m_hlen();
    for (int i = 2; i < 32; i++) if (tmpl_m[i][19]) return i - 1;
    return 30;
  endfunction

  task automatic run_pkt(input logic [15:0] bytes, input int nw, input bit stall,
                         input int newbytes, input string lreq);
    int k = 0;
    int c = 0;
    bit done = 0;
    int hl;
    ngot = 0;
    pkt_bytes = bytes;
    while (!done && c < 2000) begin
      @(negedge clk);
      if (newbytes >= 0 && c == 3) pkt_bytes = 16'(newbytes);
      out_ready = !(stall && (c % 3 == 1));
      in_valid  = (k < nw);
      in_data   = 16'hA000 + 16'(k);
      in_last   = (k == nw - 1);
      #1;
      if (out_valid && out_ready) begin
        got[ngot] = out_data; gl[ngot] = out_last; ngot++;
        if (out_last) done = 1;
      end
      if (in_valid && in_ready) k++;
      c++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    hl = m_hlen();
    chk(ngot == hl + nw, lreq, ngot, hl + nw);
    for (int j = 0; j < hl && j < ngot; j++) begin
      logic [19:0] e = tmpl_m[j + 2];
      string t = e[18] ? "R6" : e[17] ? "R4" : e[16] ? "R5" : "R3";
      chk(got[j] == m_word(j + 2, bytes) && !gl[j], t, got[j], m_word(j + 2, bytes));
    end
    for (int j = 0; j < nw && hl + j < ngot; j++)
      chk(got[hl + j] == 16'hA000 + 16'(j) && gl[hl + j] == (j == nw - 1), "R7",
          got[hl + j], 16'hA000 + 16'(j));
  endtask

  task automatic t_reset();
    #1;
    chk(!out_valid && !in_ready, "R1", {out_valid, in_ready}, 0);
  endtask

  task automatic t_known_cksum();
    logic [15:0] v [0:20];
    v = '{16'h0011, 16'h2233, 16'h4455, 16'h6677, 16'h8899, 16'hAABB, 16'h0800,
          16'h4500, 16'hDEAD, 16'h0000, 16'h4000, 16'h4011, 16'hBEEF, 16'hC0A8,
          16'h0001, 16'hC0A8, 16'h00C7, 16'h1234, 16'h5678, 16'hFACE, 16'h0000};
    wr(0, 20'h0_5555); wr(1, 20'h0_6666);
    for (int i = 0; i < 21; i++) begin
      logic [3:0] cb = (i + 2 == 10) ? 4'h2 : (i + 2 == 14) ? 4'h4 :
                       (i + 2 == 21) ? 4'h1 : (i + 2 == 22) ? 4'h8 : 4'h0;
      wr(i + 2, {cb, v[i]});
    end
    run_pkt(16'd87, 4, 0, -1, "R2");
    chk(got[12] == 16'hB861, "R6", got[12], 16'hB861);
    chk(got[8] == 16'h0073, "R4", got[8], 16'h0073);
    chk(got[0] == 16'h0011, "R2", got[0], 16'h0011);
  endtask

  task automatic t_backpressure();
    run_pkt(16'd0, 6, 1, -1, "R2");
    chk(got[19] == 16'd8, "R5", got[19], 8);
  endtask

  task automatic t_resample();
    run_pkt(16'd500, 3, 0, 3, "R8");
    chk(got[8] == 16'd528, "R8", got[8], 528);
    run_pkt(16'd3, 2, 1, -1, "R9");
    chk(got[0] == m_word(2, 16'd3) && got[8] == 16'd31, "R9", got[8], 31);
  endtask

  task automatic t_wrap();
    run_pkt(16'hFFF0, 2, 0, -1, "R4");
    chk(got[8] == 16'h000C, "R4", got[8], 16'h000C);
    chk(got[19] == 16'hFFF8, "R5", got[19], 16'hFFF8);
  endtask

  task automatic t_short();
    wr(4, 20'h9_0BAD);
    run_pkt(16'd40, 2, 1, -1, "R11");
    chk(ngot == 5 && got[2] == 16'd48, "R11", got[2], 48);
  endtask

  task automatic t_nomark();
    wr(4, 20'h0_4455);
    wr(22, 20'h0_0000);
    run_pkt(16'd10, 3, 0, -1, "R10");
    chk(ngot == 33 && got[29] == 16'h0000, "R10", ngot, 33);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) tmpl_m[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known_cksum();
    t_backpressure();
    t_resample();
    t_wrap();
    t_short();
    t_nomark();
    @(negedge clk);
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule